// File: doc/BRIEF.md
# Transposed-Form Cascaded FIR Filter

This block is a five-tap finite impulse response filter made from a chain of multiply-add cells in transposed form. Every cell captures the same input sample into its own sample register and multiplies it by the weight held in that cell. The cell adds the product to the running partial sum that arrives from the cell before it. The chain starts from a zero addend and ends at the output. The filter produces one output sample per clock. All arithmetic is two's complement on a 26-bit sum path.

Weights are written one tap at a time through a small write port that carries a tap index, the weight and a strobe. A mode input disables the combinational pass-through of every cell's sum. Each stage then gains a second register, so the chain runs as two independent filters on samples that alternate from clock to clock. An output-valid flag follows the input-valid flag. Its delay is the pipeline latency of the selected mode.

Top module: `tfir_cascade`

## Requirements
- R1: After reset, `y_out` is 0, `y_vld` is 0, all weights are 0 and all stored samples are 0.
- R2: A write with `w_wr`=1 and `w_idx`=i, for i from 0 to TAPS-1, loads the signed 12-bit `w_data` as weight h_i. Weight h_i multiplies the sample that is i steps older. Weights keep their value until that tap is written again.
- R3: A write whose index is TAPS or higher changes no weight. A single strobe never loads more than one tap.
- R4: With `ilv_mode`=0, `y_out` after clock edge t equals the sum over i of h_i·x(t-1-i). Here x(k) is the content of the sample register after edge k.
- R5: The sample register loads `smp_in` only on edges where `smp_vld`=1. Otherwise it keeps the previous sample, and that sample keeps feeding the products.
- R6: `y_vld` equals `smp_vld` delayed by 2 edges when `ilv_mode`=0 and by 3 edges when `ilv_mode`=1.
- R7: With `ilv_mode`=1, `y_out` after edge t equals the sum over i of h_i·x(t-2-2i). This filters the even-clock and odd-clock sample streams separately with the same weights.
- R8: Products and sums are signed. The sum wraps modulo 2^26. Five full-scale products (-2048·-2048) sum exactly to 20971520 with no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | Load enable for every cell's sample register |
| smp_in | input | 12 | Signed input sample, broadcast to all taps |
| w_wr | input | 1 | Weight write strobe |
| w_idx | input | 3 | Tap index of the weight write |
| w_data | input | 12 | Signed weight value |
| ilv_mode | input | 1 | 1 = two interleaved streams, 0 = one stream |
| y_out | output | 26 | Signed filter output |
| y_vld | output | 1 | Output valid, delayed copy of smp_vld |

## Verification
The hardest case to reach from the ports is a mode change or a weight rewrite while samples are still in flight. At that moment some partial sums in the chain were built with the old configuration. The stimulus switches `ilv_mode` and rewrites weights in the middle of live random streams. The reference model tracks how many clocks have passed since each change, compares the data only after the chain has refilled, and checks `y_vld` on every clock, including across the switch. Stalls on `smp_vld`, writes to indices above the top tap, and full-scale negative operands are mixed into the same runs.

// File: rtl/tfir_pkg.sv
package tfir_pkg;
   // Operating mode of the summing chain.
   typedef enum logic {
      MODE_STREAM = 1'b0,
      MODE_ILV    = 1'b1
   } tfir_mode_e;

   // Fixed architectural latencies (sample capture to output).
   localparam int LAT_STREAM = 2;
   localparam int LAT_ILV    = 3;
endpackage

// File: rtl/tfir_wsel.sv
module tfir_wsel #(
   parameter int TAPS = 5,
   parameter int IDXW = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr,
   input  logic [IDXW-1:0] idx,
   output logic [TAPS-1:0] ld_vec
);
   initial assert ((1 << IDXW) >= TAPS) else $error("tap index too narrow");

   for (genvar j = 0; j < TAPS; j++) begin : g_dec
      assign ld_vec[j] = wr && (idx == IDXW'(j));
   end

   // R3: a strobe selects at most one tap
   p_one_tap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ld_vec));
   // R3: an index beyond the top tap selects nothing
   p_oor_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && (int'(idx) >= TAPS)) |-> (ld_vec == '0));
   // R2: an in-range index loads its tap
   p_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && (int'(idx) < TAPS)) |-> (ld_vec != '0));
endmodule

// File: rtl/tfir_mac_cell.sv
module tfir_mac_cell #(
   parameter int DW = 12,
   parameter int CW = 12,
   parameter int SW = 26
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld_smp,
   input  logic [DW-1:0] smp,
   input  logic          ld_w,
   input  logic [CW-1:0] w,
   input  logic [SW-1:0] addend,
   input  logic          pass,
   output logic [SW-1:0] sum_o
);
   localparam int PW = DW + CW;
   initial assert (SW > PW) else $error("sum path must exceed product width");

   logic signed [DW-1:0] smp_q;
   logic signed [CW-1:0] w_q;
   logic signed [PW-1:0] prod_q;
   logic        [SW-1:0] add_q;
   logic        [SW-1:0] hold_q;
   logic        [SW-1:0] sum_c;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         smp_q  <= '0;
         w_q    <= '0;
         prod_q <= '0;
         add_q  <= '0;
         hold_q <= '0;
      end else begin
         if (ld_smp) smp_q <= smp;
         if (ld_w)   w_q   <= w;
         prod_q <= PW'(smp_q) * PW'(w_q);
         add_q  <= addend;
         hold_q <= sum_c;
      end
   end

   assign sum_c = {{(SW-PW){prod_q[PW-1]}}, prod_q} + add_q;
   assign sum_o = pass ? sum_c : hold_q;
endmodule

// File: rtl/tfir_vld_pipe.sv
module tfir_vld_pipe
   import tfir_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic vin,
   input  logic ilv,
   output logic vout
);
   logic [LAT_ILV-1:0] v_q;

   always_ff @(posedge clk) begin
      if (!rst_n) v_q <= '0;
      else        v_q <= {v_q[LAT_ILV-2:0], vin};
   end

   assign vout = ilv ? v_q[LAT_ILV-1] : v_q[LAT_STREAM-1];

   // R6: latency of the valid flag in each mode
   p_lat_stream_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!ilv && vout) |-> $past(vin, 2));
   p_lat_ilv_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ilv && vout) |-> $past(vin, 3));
endmodule

// File: rtl/tfir_cascade.sv
module tfir_cascade
   import tfir_pkg::*;
#(
   parameter int TAPS = 5,
   parameter int DW   = 12,
   parameter int CW   = 12,
   parameter int SW   = 26,
   parameter int IDXW = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            smp_vld,
   input  logic [DW-1:0]   smp_in,
   input  logic            w_wr,
   input  logic [IDXW-1:0] w_idx,
   input  logic [CW-1:0]   w_data,
   input  logic            ilv_mode,
   output logic [SW-1:0]   y_out,
   output logic            y_vld
);
   initial assert (TAPS >= 1) else $error("at least one tap required");

   tfir_mode_e      mode;
   logic            pass;
   logic [TAPS-1:0] ld_vec;
   logic [SW-1:0]   link [TAPS];
   logic [SW-1:0]   psum [TAPS];

   assign mode = tfir_mode_e'(ilv_mode);
   assign pass = (mode == MODE_STREAM);

   tfir_wsel #(.TAPS(TAPS), .IDXW(IDXW)) i_wsel (
      .clk(clk), .rst_n(rst_n), .wr(w_wr), .idx(w_idx), .ld_vec(ld_vec)
   );

   // Stage j holds weight h(TAPS-1-j); stage 0 starts from a zero addend.
   for (genvar j = 0; j < TAPS; j++) begin : g_stage
      if (j == 0) begin : g_head
         assign link[j] = '0;
      end else begin : g_body
         assign link[j] = psum[j-1];
      end
      tfir_mac_cell #(.DW(DW), .CW(CW), .SW(SW)) i_cell (
         .clk(clk), .rst_n(rst_n),
         .ld_smp(smp_vld), .smp(smp_in),
         .ld_w(ld_vec[TAPS-1-j]), .w(w_data),
         .addend(link[j]), .pass(pass), .sum_o(psum[j])
      );
   end

   assign y_out = psum[TAPS-1];

   tfir_vld_pipe i_vld (
      .clk(clk), .rst_n(rst_n), .vin(smp_vld), .ilv(ilv_mode), .vout(y_vld)
   );
endmodule

// File: tb/test_tfir_cascade.sv
`timescale 1ns/1ps
module test_tfir_cascade;
   localparam int TAPS = 5;
   localparam int HD   = 16;
   localparam int SETTLE = 2*TAPS + 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_vld = 1'b0;
   logic [11:0] smp_in = '0;
   logic        w_wr = 1'b0;
   logic [2:0]  w_idx = '0;
   logic [11:0] w_data = '0;
   logic        ilv_mode = 1'b0;
   logic [25:0] y_out;
   logic        y_vld;

   always #2.5 clk = ~clk;

   tfir_cascade i_tfir_cascade (
      .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_in(smp_in),
      .w_wr(w_wr), .w_idx(w_idx), .w_data(w_data), .ilv_mode(ilv_mode),
      .y_out(y_out), .y_vld(y_vld)
   );

   int    n_chk = 0;
   int    n_bad = 0;
   bit    done = 0;
   string tag = "R1";
   int    ah [HD];
   bit    vh [HD];
   int    hm [8];
   int    stable = 100;
   bit    last_mode = 0;

   function automatic int sx12(input logic [11:0] v);
      return int'($signed(v));
   endfunction

   task automatic chk(input string req, input logic [25:0] act, input logic [25:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d (0x%07h) expected %0d (0x%07h)",
                  req, $signed(act), act, $signed(exp), exp);
      end
   endtask

   // Model step: mirrors one rising edge using the values just driven.
   task automatic model_edge();
      for (int i = HD-1; i > 0; i--) begin
         ah[i] = ah[i-1];
         vh[i] = vh[i-1];
      end
      ah[0] = smp_vld ? sx12(smp_in) : ah[1];
      vh[0] = smp_vld;
      if (w_wr && int'(w_idx) < TAPS) begin
         hm[w_idx] = sx12(w_data);
         stable = 0;
      end else if (ilv_mode != last_mode) begin
         stable = 0;
      end else begin
         stable++;
      end
      last_mode = ilv_mode;
   endtask

   task automatic compare();
      logic [25:0] acc;
      bit ev;
      ev = ilv_mode ? vh[2] : vh[1];
      chk("R6 valid latency", {25'd0, y_vld}, {25'd0, ev});
      if (stable >= SETTLE) begin
         acc = '0;
         for (int i = 0; i < TAPS; i++)
            acc += ilv_mode ? 26'(hm[i] * ah[2 + 2*i]) : 26'(hm[i] * ah[1 + i]);
         chk(tag, y_out, acc);
      end
   endtask

   task automatic cyc(input logic v, input logic [11:0] x, input logic wr,
                      input logic [2:0] idx, input logic [11:0] wd, input logic md);
      smp_vld = v; smp_in = x; w_wr = wr; w_idx = idx; w_data = wd; ilv_mode = md;
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare();
   endtask

   task automatic wr_coef(input int i, input int val, input logic md);
      cyc(1'b1, 12'(sx12(12'($urandom))), 1'b1, 3'(i), 12'(val), md);
   endtask

   initial begin
      for (int i = 0; i < HD; i++) begin ah[i] = 0; vh[i] = 0; end
      for (int i = 0; i < 8; i++) hm[i] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      chk("R1 reset y_out", y_out, 26'd0);
      chk("R1 reset y_vld", {25'd0, y_vld}, 26'd0);
      cyc(1'b0, '0, 1'b0, '0, '0, 1'b0);
      chk("R1 zero weights", y_out, 26'd0);

      // R2: load weights and drive an impulse
      tag = "R2 impulse";
      wr_coef(0, 3, 0); wr_coef(1, -5, 0); wr_coef(2, 7, 0);
      wr_coef(3, 11, 0); wr_coef(4, -2, 0);
      repeat (SETTLE) cyc(1'b1, 12'd0, 1'b0, '0, '0, 1'b0);
      cyc(1'b1, 12'd1, 1'b0, '0, '0, 1'b0);
      repeat (12) cyc(1'b1, 12'd0, 1'b0, '0, '0, 1'b0);

      // R4: continuous random stream
      tag = "R4 stream";
      repeat (150) cyc(1'b1, 12'($urandom), 1'b0, '0, '0, 1'b0);

      // R5: stalls hold the sample
      tag = "R5 stall hold";
      repeat (150) cyc(1'($urandom_range(0, 2) != 0), 12'($urandom), 1'b0, '0, '0, 1'b0);

      // R3: out-of-range writes ignored while streaming
      tag = "R3 ignored write";
      for (int k = 0; k < 40; k++)
         cyc(1'b1, 12'($urandom), (k % 3) == 0, 3'(TAPS + (k % 3)), 12'h7ff, 1'b0);

      // R2: weight rewrite mid-stream, then random weights
      tag = "R2 rewrite";
      for (int i = 0; i < TAPS; i++) wr_coef(i, int'($urandom_range(0, 4095)) - 2048, 0);
      repeat (100) cyc(1'b1, 12'($urandom), 1'b0, '0, '0, 1'b0);

      // R8: full-scale negative operands
      tag = "R8 full scale";
      for (int i = 0; i < TAPS; i++) wr_coef(i, -2048, 0);
      repeat (SETTLE + 4) cyc(1'b1, 12'h800, 1'b0, '0, '0, 1'b0);
      chk("R8 headroom sum", y_out, 26'd20971520);
      repeat (60) cyc(1'b1, ($urandom_range(0, 1) != 0) ? 12'h800 : 12'h7ff,
                      1'b0, '0, '0, 1'b0);

      // R7: interleaved mode, two streams
      tag = "R7 interleaved";
      for (int i = 0; i < TAPS; i++) wr_coef(i, int'($urandom_range(0, 4095)) - 2048, 0);
      repeat (200) cyc(1'($urandom_range(0, 5) != 0), 12'($urandom), 1'b0, '0, '0, 1'b1);
      tag = "R7 interleaved impulse";
      repeat (SETTLE) cyc(1'b1, 12'd0, 1'b0, '0, '0, 1'b1);
      cyc(1'b1, 12'd1, 1'b0, '0, '0, 1'b1);
      repeat (14) cyc(1'b1, 12'd0, 1'b0, '0, '0, 1'b1);

      // R4: back to single stream after the mode switch
      tag = "R4 after switch";
      repeat (80) cyc(1'b1, 12'($urandom), 1'b0, '0, '0, 1'b0);

      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule